// File: doc/BRIEF.md
# Bitstream DSP Pipeline Control Registers

This block is a Wishbone B4 slave that holds the run-time settings of a bitstream signal chain made of a decimator, a tap-programmable filter and a pulse-density output stage. A processor reaches it through word-aligned offsets. Every access, including one to an offset that holds nothing, gets an acknowledge in the cycle after the request. Read data is returned in that same cycle.

The register outputs drive the chain directly. They carry a run gate, two stage bypasses, a datapath reset level, the choice of the internal pseudo-random test source, the decimation ratio and the direct value for the output stage. Filter taps are loaded indirectly: software first sets a tap index, then writes the coefficient word. That write produces a single-cycle load strobe carrying the new coefficient and the held index. The filter's output-valid pulse can be read back as a status bit.

Top module: `dsp_ctl_regs`

## Requirements
- R1: After reset the control word reads 0x01 (run gate on, all other control bits off), the ratio reads 16, the tap index and coefficient read 0, the direct output value reads 0x80, and both acknowledge and load strobe are low.
- R2: A request (cycle and strobe high while acknowledge is low) is acknowledged in the next cycle for exactly one cycle, with read data valid in that cycle. A request held high is acknowledged every other cycle.
- R3: Offset 0x00 is the control word. Bit 0 is the run gate, bit 1 bypasses the filter, bit 2 bypasses the decimator, bit 3 is the datapath reset level and bit 4 selects the internal test source. A write shows on the outputs in the acknowledge cycle.
- R4: Offset 0x04 bits [6:0] hold the decimation ratio. A write of 8, 16, 32 or 64 takes effect. Any other value is ignored and the old ratio is kept.
- R5: Offset 0x08 bits [2:0] hold the tap index.
- R6: Offset 0x0C bits [15:0] hold the coefficient. A write raises the load strobe for exactly one cycle, in the acknowledge cycle. During that cycle the strobe carries the written coefficient and the tap index held at that time.
- R7: Offset 0x10 is read-only status. Bit 0 is the filter output-valid input as sampled in the request cycle. Writes to it change nothing.
- R8: Offset 0x14 bits [7:0] hold the direct output value.
- R9: All registers are 32 bits wide. Bits outside the defined fields read 0 and are ignored on writes. Read data is 0 outside acknowledge cycles.
- R10: A write whose byte selects are not all four ones is acknowledged but changes no register and raises no load strobe.
- R11: An access to an offset at 0x18 or above is acknowledged, reads 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1..2) |
| wb_sel_i | input | DATA_W/8 | Byte selects |
| wb_dat_i | input | DATA_W | Write data |
| wb_dat_o | output | DATA_W | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| fir_valid_i | input | 1 | Filter output-valid pulse |
| run_en_o | output | 1 | Pipeline run gate |
| fir_bypass_o | output | 1 | Filter bypass |
| cic_bypass_o | output | 1 | Decimator bypass |
| dp_srst_o | output | 1 | Datapath reset level |
| lfsr_sel_o | output | 1 | Internal test source select |
| decim_o | output | OSR_W | Decimation ratio |
| tap_wr_o | output | 1 | Coefficient load strobe |
| tap_idx_o | output | TIDX_W | Tap index |
| tap_val_o | output | COEF_W | Coefficient value |
| pwm_val_o | output | PWM_W | Direct output value |

## Verification
The coefficient load strobe and a change of the tap index are the two events that could share a cycle. The bench writes a coefficient and then immediately writes a new index. It checks that during the strobe cycle the index output still holds the old value, and that the strobe is already low when the new index appears. A second overlap is a valid pulse from the filter that coincides with a status read request. The bench raises the valid input only in the request cycle and expects bit 0 of the returned word to be set.

// File: rtl/dsp_ctl_pkg.sv
package dsp_ctl_pkg;

  // word slots (byte offset / 4); the index of each register is what software decodes
  localparam int SLOT_CTRL   = 0;
  localparam int SLOT_DECIM  = 1;
  localparam int SLOT_TIDX   = 2;
  localparam int SLOT_TVAL   = 3;
  localparam int SLOT_STAT   = 4;
  localparam int SLOT_PWM    = 5;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic src_int;   // bit 4
    logic dp_srst;   // bit 3
    logic skip_cic;  // bit 2
    logic skip_fir;  // bit 1
    logic run_en;    // bit 0
  } ctrl_t;

  localparam int    CTRL_W   = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{src_int: 1'b0, dp_srst: 1'b0, skip_cic: 1'b0,
                                 skip_fir: 1'b0, run_en: 1'b1};

endpackage

// File: rtl/dsp_ctl_wbport.sv
module dsp_ctl_wbport #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  output logic             ack,
  output logic             rd_req,
  output logic             wr_req
);

  logic accept;

  // a new request is taken only while no acknowledge is out
  assign accept = cyc & stb & ~ack;
  assign rd_req = accept & ~we;
  assign wr_req = accept & we & (&sel);

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= accept;
  end

  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc && stb && !ack) |=> ack);

  assert_ack_single_R2: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

endmodule

// File: rtl/dsp_ctl_store.sv
module dsp_ctl_store
  import dsp_ctl_pkg::*;
#(
  parameter int          SLOT_W  = 6,
  parameter int          OSR_W   = 7,
  parameter int          OSR_RST = 16,
  parameter int          OSR_MIN = 8,
  parameter int          OSR_MAX = 64,
  parameter int          TIDX_W  = 3,
  parameter int          COEF_W  = 16,
  parameter int          PWM_W   = 8,
  parameter int          PWM_RST = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [SLOT_W-1:0] slot,
  input  logic [COEF_W-1:0] wdat,
  output ctrl_t             ctrl_q,
  output logic [OSR_W-1:0]  osr_q,
  output logic [TIDX_W-1:0] tidx_q,
  output logic [COEF_W-1:0] tval_q,
  output logic [PWM_W-1:0]  pwm_q,
  output logic              tap_wr
);

  logic [OSR_W-1:0] osr_cand;
  logic             osr_ok;

  assign osr_cand = wdat[OSR_W-1:0];
  // legal ratios are the powers of two between the limits
  assign osr_ok = $onehot(osr_cand) &&
                  (osr_cand >= OSR_W'(OSR_MIN)) &&
                  (osr_cand <= OSR_W'(OSR_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      osr_q  <= OSR_W'(OSR_RST);
      tidx_q <= '0;
      tval_q <= '0;
      pwm_q  <= PWM_W'(PWM_RST);
      tap_wr <= 1'b0;
    end else begin
      tap_wr <= 1'b0;
      if (wr_req) begin
        case (slot)
          SLOT_W'(SLOT_CTRL):  ctrl_q <= ctrl_t'(wdat[CTRL_W-1:0]);
          SLOT_W'(SLOT_DECIM): if (osr_ok) osr_q <= osr_cand;
          SLOT_W'(SLOT_TIDX):  tidx_q <= wdat[TIDX_W-1:0];
          SLOT_W'(SLOT_TVAL): begin
            tval_q <= wdat;
            tap_wr <= 1'b1;
          end
          SLOT_W'(SLOT_PWM):   pwm_q <= wdat[PWM_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assert_osr_legal_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot(osr_q) && (osr_q >= OSR_W'(OSR_MIN)) && (osr_q <= OSR_W'(OSR_MAX)));

  assert_tap_pulse_one_R6: assert property (@(posedge clk) disable iff (rst)
    tap_wr |=> !tap_wr);

  assert_tap_from_write_R6: assert property (@(posedge clk) disable iff (rst)
    tap_wr |-> $past(wr_req));

  assert_pwm_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> $stable(pwm_q));

  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> $stable(tidx_q));

endmodule

// File: rtl/dsp_ctl_rdmux.sv
module dsp_ctl_rdmux
  import dsp_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SLOT_W = 6,
  parameter int OSR_W  = 7,
  parameter int TIDX_W = 3,
  parameter int COEF_W = 16,
  parameter int PWM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [SLOT_W-1:0] slot,
  input  ctrl_t             ctrl_q,
  input  logic [OSR_W-1:0]  osr_q,
  input  logic [TIDX_W-1:0] tidx_q,
  input  logic [COEF_W-1:0] tval_q,
  input  logic [PWM_W-1:0]  pwm_q,
  input  logic              stat_bit,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] word;

  always_comb begin
    case (slot)
      SLOT_W'(SLOT_CTRL):  word = DATA_W'(ctrl_q);
      SLOT_W'(SLOT_DECIM): word = DATA_W'(osr_q);
      SLOT_W'(SLOT_TIDX):  word = DATA_W'(tidx_q);
      SLOT_W'(SLOT_TVAL):  word = DATA_W'(tval_q);
      SLOT_W'(SLOT_STAT):  word = DATA_W'(stat_bit);
      SLOT_W'(SLOT_PWM):   word = DATA_W'(pwm_q);
      default:             word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_req) rdata <= word;
    else             rdata <= '0;
  end

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (rdata == '0));

endmodule

// File: rtl/dsp_ctl_regs.sv
module dsp_ctl_regs
  import dsp_ctl_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int OSR_W   = 7,
  parameter int OSR_RST = 16,
  parameter int OSR_MIN = 8,
  parameter int OSR_MAX = 64,
  parameter int TIDX_W  = 3,
  parameter int COEF_W  = 16,
  parameter int PWM_W   = 8,
  parameter int PWM_RST = 128,
  localparam int SEL_W  = DATA_W / 8,
  localparam int SLOT_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:2] wb_adr_i,
  input  logic [SEL_W-1:0]  wb_sel_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  input  logic              fir_valid_i,
  output logic              run_en_o,
  output logic              fir_bypass_o,
  output logic              cic_bypass_o,
  output logic              dp_srst_o,
  output logic              lfsr_sel_o,
  output logic [OSR_W-1:0]  decim_o,
  output logic              tap_wr_o,
  output logic [TIDX_W-1:0] tap_idx_o,
  output logic [COEF_W-1:0] tap_val_o,
  output logic [PWM_W-1:0]  pwm_val_o
);

  logic              rd_req;
  logic              wr_req;
  logic [SLOT_W-1:0] slot;
  ctrl_t             ctrl_q;
  logic              unused_hi;

  assign slot      = wb_adr_i;
  assign unused_hi = ^wb_dat_i[DATA_W-1:COEF_W];

  dsp_ctl_wbport #(.SEL_W(SEL_W)) u_port (
    .clk(clk), .rst(rst), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
    .sel(wb_sel_i), .ack(wb_ack_o), .rd_req(rd_req), .wr_req(wr_req)
  );

  dsp_ctl_store #(
    .SLOT_W(SLOT_W), .OSR_W(OSR_W), .OSR_RST(OSR_RST), .OSR_MIN(OSR_MIN),
    .OSR_MAX(OSR_MAX), .TIDX_W(TIDX_W), .COEF_W(COEF_W), .PWM_W(PWM_W),
    .PWM_RST(PWM_RST)
  ) u_store (
    .clk(clk), .rst(rst), .wr_req(wr_req), .slot(slot),
    .wdat(wb_dat_i[COEF_W-1:0]), .ctrl_q(ctrl_q), .osr_q(decim_o),
    .tidx_q(tap_idx_o), .tval_q(tap_val_o), .pwm_q(pwm_val_o), .tap_wr(tap_wr_o)
  );

  dsp_ctl_rdmux #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W), .OSR_W(OSR_W), .TIDX_W(TIDX_W),
    .COEF_W(COEF_W), .PWM_W(PWM_W)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd_req(rd_req), .slot(slot), .ctrl_q(ctrl_q),
    .osr_q(decim_o), .tidx_q(tap_idx_o), .tval_q(tap_val_o), .pwm_q(pwm_val_o),
    .stat_bit(fir_valid_i), .rdata(wb_dat_o)
  );

  assign run_en_o     = ctrl_q.run_en;
  assign fir_bypass_o = ctrl_q.skip_fir;
  assign cic_bypass_o = ctrl_q.skip_cic;
  assign dp_srst_o    = ctrl_q.dp_srst;
  assign lfsr_sel_o   = ctrl_q.src_int;

  assert_tap_in_ack_R6: assert property (@(posedge clk) disable iff (rst)
    tap_wr_o |-> wb_ack_o);

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(wb_cyc_i && wb_stb_i && wb_we_i) |=> $stable(ctrl_q));

endmodule

// File: tb/dsp_ctl_regs_bench.sv
module dsp_ctl_regs_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [7:0]  adr;
    logic [31:0] wd;
    logic [3:0]  sel;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // reads compare exp; writes only check the acknowledge
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,         4'hF, 32'h01,   8'd1},  // R1 control default
    '{1'b0, 8'h04, 32'h0,         4'hF, 32'd16,   8'd1},  // R1 ratio default
    '{1'b0, 8'h14, 32'h0,         4'hF, 32'h80,   8'd1},  // R1 direct default
    '{1'b1, 8'h00, 32'hFFFF_FF1E, 4'hF, 32'h0,    8'd3},  // R3 write
    '{1'b0, 8'h00, 32'h0,         4'hF, 32'h1E,   8'd9},  // R9 upper bits dropped
    '{1'b1, 8'h04, 32'd32,        4'hF, 32'h0,    8'd4},  // R4 legal
    '{1'b0, 8'h04, 32'h0,         4'hF, 32'd32,   8'd4},
    '{1'b1, 8'h04, 32'd24,        4'hF, 32'h0,    8'd4},  // R4 illegal
    '{1'b0, 8'h04, 32'h0,         4'hF, 32'd32,   8'd4},
    '{1'b1, 8'h14, 32'hABCD_1234, 4'hF, 32'h0,    8'd8},  // R8
    '{1'b0, 8'h14, 32'h0,         4'hF, 32'h34,   8'd8},
    '{1'b1, 8'h14, 32'h55,        4'h1, 32'h0,    8'd10}, // R10 partial
    '{1'b0, 8'h14, 32'h0,         4'hF, 32'h34,   8'd10},
    '{1'b1, 8'h08, 32'hFFFF_FFFD, 4'hF, 32'h0,    8'd5},  // R5
    '{1'b0, 8'h08, 32'h0,         4'hF, 32'd5,    8'd5},
    '{1'b1, 8'h1C, 32'hFFFF,      4'hF, 32'h0,    8'd11}, // R11
    '{1'b0, 8'h1C, 32'h0,         4'hF, 32'h0,    8'd11},
    '{1'b1, 8'h10, 32'hFF,        4'hF, 32'h0,    8'd7},  // R7 write ignored
    '{1'b0, 8'h10, 32'h0,         4'hF, 32'h0,    8'd7}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0, fv = 1'b0;
  logic [7:2]  adr = '0;
  logic [3:0]  sel = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic        ack, run_en, skip_fir, skip_cic, srst, src_int, tap_wr;
  logic [6:0]  decim;
  logic [2:0]  tidx;
  logic [15:0] tval;
  logic [7:0]  pwm;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_ctl_regs u_dsp_ctl_regs (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(rdat),
    .wb_ack_o(ack), .fir_valid_i(fv), .run_en_o(run_en), .fir_bypass_o(skip_fir),
    .cic_bypass_o(skip_cic), .dp_srst_o(srst), .lfsr_sel_o(src_int),
    .decim_o(decim), .tap_wr_o(tap_wr), .tap_idx_o(tidx), .tap_val_o(tval),
    .pwm_val_o(pwm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // one transfer; returns values seen in the acknowledge cycle
  logic        x_ack, x_tw;
  logic [31:0] x_rd;
  logic [2:0]  x_ti;
  logic [15:0] x_tv;
  task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] s, input logic valid_in);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a[7:2]; wdat = d; sel = s; fv = valid_in;
    @(negedge clk);
    x_ack = ack; x_rd = rdat; x_tw = tap_wr; x_ti = tidx; x_tv = tval;
    cyc = 1'b0; stb = 1'b0; we = 1'b0; fv = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    chk("R1 ack", 32'(ack), 32'h0);
    chk("R1 strobe", 32'(tap_wr), 32'h0);
    chk("R1 ctrl", {27'h0, src_int, srst, skip_cic, skip_fir, run_en}, 32'h1);
    chk("R1 ratio", 32'(decim), 32'd16);
    chk("R1 tap", {13'h0, tidx, tval}, 32'h0);
    chk("R1 pwm", 32'(pwm), 32'h80);

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].we, VECS[i].adr, VECS[i].wd, VECS[i].sel, 1'b0);
      chk($sformatf("R%0d ack v%0d", VECS[i].req, i), 32'(x_ack), 32'h1);
      if (!VECS[i].we)
        chk($sformatf("R%0d read v%0d", VECS[i].req, i), x_rd, VECS[i].exp);
    end

    // R3 control bits at the ports: 0x15 = run, cic bypass, internal source
    xfer(1'b1, 8'h00, 32'h15, 4'hF, 1'b0);
    chk("R3 ctrl outputs", {27'h0, src_int, srst, skip_cic, skip_fir, run_en}, 32'h15);
    xfer(1'b1, 8'h00, 32'h0A, 4'hF, 1'b0);
    chk("R3 ctrl outputs 2", {27'h0, src_int, srst, skip_cic, skip_fir, run_en}, 32'h0A);

    // R4 ratio at the ports
    xfer(1'b1, 8'h04, 32'd64, 4'hF, 1'b0);
    chk("R4 ratio 64", 32'(decim), 32'd64);
    xfer(1'b1, 8'h04, 32'd0, 4'hF, 1'b0);
    chk("R4 ratio 0 ignored", 32'(decim), 32'd64);
    xfer(1'b1, 8'h04, 32'd4, 4'hF, 1'b0);
    chk("R4 ratio 4 ignored", 32'(decim), 32'd64);
    xfer(1'b1, 8'h04, 32'd8, 4'hF, 1'b0);
    chk("R4 ratio 8", 32'(decim), 32'd8);

    // R6 coefficient load, followed at once by an index change
    xfer(1'b1, 8'h08, 32'd3, 4'hF, 1'b0);
    xfer(1'b1, 8'h0C, 32'h0001_8001, 4'hF, 1'b0);
    chk("R6 strobe high", 32'(x_tw), 32'h1);
    chk("R6 strobe index", 32'(x_ti), 32'd3);
    chk("R6 strobe value", 32'(x_tv), 32'h8001);
    xfer(1'b1, 8'h08, 32'd6, 4'hF, 1'b0);
    chk("R6 strobe gone", 32'(x_tw), 32'h0);
    chk("R5 new index", 32'(tidx), 32'd6);
    xfer(1'b0, 8'h0C, 32'h0, 4'hF, 1'b0);
    chk("R6 readback", x_rd, 32'h8001);

    // R10 partial coefficient write: no strobe, value kept
    xfer(1'b1, 8'h0C, 32'h1234, 4'h3, 1'b0);
    chk("R10 no strobe", 32'(x_tw), 32'h0);
    chk("R10 value kept", 32'(tval), 32'h8001);

    // R11 undefined offset write touches nothing
    xfer(1'b1, 8'h18, 32'hFFFF_FFFF, 4'hF, 1'b0);
    chk("R11 no strobe", 32'(x_tw), 32'h0);
    chk("R11 pwm kept", 32'(pwm), 32'h34);
    chk("R11 ratio kept", 32'(decim), 32'd8);

    // R7 valid pulse coinciding with a status read
    xfer(1'b0, 8'h10, 32'h0, 4'hF, 1'b1);
    chk("R7 status set", x_rd, 32'h1);

    // R9 read data idle after the acknowledge
    @(negedge clk);
    chk("R9 idle data", rdat, 32'h0);

    // R2 request held: acknowledges on alternate cycles
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 6'h01; sel = 4'hF;
    @(negedge clk); chk("R2 ack 1", 32'(ack), 32'h1);
    @(negedge clk); chk("R2 ack gap", 32'(ack), 32'h0);
    @(negedge clk); chk("R2 ack 2", 32'(ack), 32'h1);
    cyc = 1'b0; stb = 1'b0;
    @(negedge clk); chk("R2 ack low", 32'(ack), 32'h0);

    finish_run();
  end

endmodule